// File: doc/BRIEF.md
# Activity-Driven System Clock Divider

This block produces the general system clock from a fast base clock. While the system is quiet, the output runs at a reduced rate that software selects. As soon as an interrupt of high enough priority is pending, or a background controller is busy and allowed to count as activity, the next output period runs at the undivided rate. When that activity ends, the block drops back to the reduced rate by itself.

Time inside the block is counted in base-clock cycles. Each base-clock cycle stands for one half-period of the undivided output. At ratio N, the output stays high for one base cycle and low for 2N-1 base cycles. So only the low phase stretches, and a divided output does not have a 50% duty cycle. Every output copy comes straight from its own flip-flop. The ratio changes only where one period ends and the next begins, so no runt pulse can appear.

Top module: `sysclk_divider`

## Requirements
- R1: While reset is asserted, and in the first base cycle after it, every output copy is high and `fast_o` is high. The first period after reset runs at ratio 1.
- R2: Each output period at ratio N has one high base cycle and then 2N-1 low base cycles. `lo_div_sel` picks N for the reduced rate: 2'b00 selects 1, 2'b01 selects 2, and 2'b10 or 2'b11 selects 4.
- R3: If `irq_level` is strictly greater than `irq_thresh` (both unsigned), the next period runs at ratio 1. If the two are equal, the interrupt input causes no wake-up.
- R4: An `irq_level` of 0 never causes a wake-up, whatever the threshold.
- R5: `ctrl_busy` causes a wake-up only while `busy_wake_en` is 1. While `busy_wake_en` is 0, `ctrl_busy` has no effect on the output.
- R6: When neither wake condition holds, the next period runs at the ratio that `lo_div_sel` selects.
- R7: The ratio is chosen only at a period boundary. The choice uses the inputs that the block registered on the clock edge at which the last base cycle of the current period begins. Input changes at any other time do not alter the period in progress.
- R8: All `NUM_OUT` output copies are identical in every base cycle.
- R9: `fast_o` is high in exactly those base cycles that belong to a period running at ratio 1, and it changes only when a new period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_level | input | LVL_W | Level of the pending or current interrupt (0 means none) |
| irq_thresh | input | LVL_W | An interrupt level above this value wakes the clock |
| ctrl_busy | input | 1 | Background controller has a request or is busy |
| busy_wake_en | input | 1 | Lets `ctrl_busy` wake the clock |
| lo_div_sel | input | 2 | Ratio used at the reduced rate |
| gclk_o | output | NUM_OUT | Generated system clock copies |
| fast_o | output | 1 | Current period runs at ratio 1 |

## Verification
The bench targets the points where the rate changes. It pulses a wake input for a single cycle in the middle of a slow period. A design that switches rate immediately, instead of at the boundary, would cut a low phase short. The bench also sets the level equal to the threshold and tries level 0 with threshold 0. A design that compares with "greater or equal" would wake at the wrong time. It raises busy with the enable off, which exposes a design that ignores the gate. It sets the reduced ratio to 1 and checks that `fast_o` stays high, and it uses code 2'b11, which must map to ratio 4. Mismatched output copies, or a duty cycle that stretches the wrong phase, show up in the comparison against the model that runs every cycle.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;
  // widths fixed by the ratio set {1,2,4}
  localparam int SEL_W = 2;
  localparam int SH_W  = 2;               // log2 of the ratio, 0..2
  localparam int MAX_SH = 2;
  localparam int CNT_W = MAX_SH + 1;      // counts 0 .. 2*4-1

  typedef logic [SH_W-1:0]  shift_t;
  typedef logic [CNT_W-1:0] count_t;

  // map the reduced-rate selector onto a ratio exponent
  function automatic shift_t sel_to_shift(input logic [SEL_W-1:0] sel);
    shift_t s;
    case (sel)
      2'b00:   s = shift_t'(0);
      2'b01:   s = shift_t'(1);
      default: s = shift_t'(MAX_SH);
    endcase
    return s;
  endfunction

  // last count value of a period with ratio 2**sh: 2*N - 1
  function automatic count_t period_last(input shift_t sh);
    logic [CNT_W:0] full;
    full = ({{CNT_W{1'b0}}, 1'b1} << (sh + 1));
    return count_t'(full - 1'b1);
  endfunction
endpackage

// File: rtl/sysclk_wake_eval.sv
module sysclk_wake_eval
  import sysclk_div_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] irq_level,
  input  logic [LVL_W-1:0] irq_thresh,
  input  logic             ctrl_busy,
  input  logic             busy_wake_en,
  input  logic [SEL_W-1:0] lo_div_sel,
  output shift_t           next_sh_q,
  output logic             wake_q
);
  logic irq_wake, busy_wake, wake_now;

  assign irq_wake  = (irq_level > irq_thresh);
  assign busy_wake = ctrl_busy & busy_wake_en;
  assign wake_now  = irq_wake | busy_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q    <= 1'b1;
      next_sh_q <= '0;
    end else begin
      wake_q    <= wake_now;
      next_sh_q <= wake_now ? shift_t'(0) : sel_to_shift(lo_div_sel);
    end
  end

  // R3
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level > irq_thresh) |=> (next_sh_q == shift_t'(0)));

  // R4
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_level == '0) && !ctrl_busy) |=> (next_sh_q == sel_to_shift($past(lo_div_sel))));

  // R5
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_wake_en && (irq_level <= irq_thresh)) |=> !wake_q);
endmodule

// File: rtl/sysclk_period_gen.sv
module sysclk_period_gen
  import sysclk_div_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  shift_t next_sh,
  output count_t cnt_nxt,
  output shift_t cur_sh,
  output logic   boundary
);
  count_t cnt;
  shift_t sh_nxt;

  assign boundary = (cnt == period_last(cur_sh));
  assign cnt_nxt  = boundary ? '0 : count_t'(cnt + 1'b1);
  assign sh_nxt   = boundary ? next_sh : cur_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      cur_sh <= '0;
    end else begin
      cnt    <= cnt_nxt;
      cur_sh <= sh_nxt;
    end
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period_last(cur_sh));

  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(cur_sh));

  // R7
  ratio_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cur_sh == $past(next_sh)));
endmodule

// File: rtl/sysclk_clk_out.sv
module sysclk_clk_out
  import sysclk_div_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  count_t             cnt_nxt,
  output logic [NUM_OUT-1:0] gclk_q
);
  logic start_nxt;
  assign start_nxt = (cnt_nxt == '0);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gclk_q[g] <= 1'b1;
      else        gclk_q[g] <= start_nxt;
    end
  end

  // R8
  copies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gclk_q == {NUM_OUT{gclk_q[0]}});

  // R2
  high_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gclk_q[0] |=> !gclk_q[0]);
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import sysclk_div_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   irq_level,
  input  logic [LVL_W-1:0]   irq_thresh,
  input  logic               ctrl_busy,
  input  logic               busy_wake_en,
  input  logic [1:0]         lo_div_sel,
  output logic [NUM_OUT-1:0] gclk_o,
  output logic               fast_o
);
  shift_t next_sh;
  shift_t cur_sh;
  count_t cnt_nxt;
  logic   wake_q;
  logic   boundary;

  sysclk_wake_eval #(.LVL_W(LVL_W)) wake_i (
    .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .irq_thresh(irq_thresh),
    .ctrl_busy(ctrl_busy), .busy_wake_en(busy_wake_en), .lo_div_sel(lo_div_sel),
    .next_sh_q(next_sh), .wake_q(wake_q)
  );

  sysclk_period_gen per_i (
    .clk(clk), .rst_n(rst_n), .next_sh(next_sh),
    .cnt_nxt(cnt_nxt), .cur_sh(cur_sh), .boundary(boundary)
  );

  sysclk_clk_out #(.NUM_OUT(NUM_OUT)) out_i (
    .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .gclk_q(gclk_o)
  );

  assign fast_o = (cur_sh == shift_t'(0));

  // R9
  fast_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fast_o) |-> gclk_o[0]);

  // R3
  wake_forces_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && wake_q) |=> fast_o);
endmodule

// File: tb/sysclk_divider_tb.sv
module sysclk_divider_tb_top;
  localparam int LVL_W = 3;
  localparam int NUM_OUT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LVL_W-1:0] irq_level = '0, irq_thresh = '0;
  logic ctrl_busy = 1'b0, busy_wake_en = 1'b0;
  logic [1:0] lo_div_sel = 2'b00;
  logic [NUM_OUT-1:0] gclk_o;
  logic fast_o;

  int n_checks = 0, n_fail = 0;
  int exp_q[$];
  bit exp_fast;
  bit pend_wake;
  int pend_ratio;
  string req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  sysclk_divider #(.LVL_W(LVL_W), .NUM_OUT(NUM_OUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .irq_thresh(irq_thresh),
    .ctrl_busy(ctrl_busy), .busy_wake_en(busy_wake_en), .lo_div_sel(lo_div_sel),
    .gclk_o(gclk_o), .fast_o(fast_o)
  );

  function automatic int ratio_of(input logic [1:0] s);
    if (s == 2'b00) return 1;
    if (s == 2'b01) return 2;
    return 4;
  endfunction

  function automatic bit wants_fast(input int lvl, input int thr, input bit busy, input bit en);
    return (lvl > thr) || (busy && en);
  endfunction

  task automatic check(input string r, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic note_inputs();
    pend_wake  = wants_fast(int'(irq_level), int'(irq_thresh), ctrl_busy, busy_wake_en);
    pend_ratio = pend_wake ? 1 : ratio_of(lo_div_sel);
  endtask

  // one base cycle: compare at the falling edge, advance the model, drive new inputs
  task automatic cyc(input int lvl, input int thr, input bit busy, input bit en, input logic [1:0] sel);
    @(negedge clk);
    check(req, int'(gclk_o[0]), exp_q[0], "gclk");
    check(req, int'(fast_o), int'(exp_fast), "fast");
    check("R8", int'(gclk_o[1]), int'(gclk_o[0]), "copy");
    void'(exp_q.pop_front());
    if (exp_q.size() == 0) begin
      exp_fast = (pend_ratio == 1);
      exp_q.push_back(1);
      for (int i = 0; i < 2 * pend_ratio - 1; i++) exp_q.push_back(0);
    end
    irq_level = LVL_W'(lvl); irq_thresh = LVL_W'(thr);
    ctrl_busy = busy; busy_wake_en = en; lo_div_sel = sel;
    note_inputs();
  endtask

  task automatic run(input int n, input int lvl, input int thr, input bit busy, input bit en, input logic [1:0] sel);
    for (int i = 0; i < n; i++) cyc(lvl, thr, busy, en, sel);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int lvl, thr;
    bit b, e;
    logic [1:0] s;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(gclk_o[0]), 1, "gclk in reset");
    check("R1", int'(gclk_o[1]), 1, "gclk copy in reset");
    check("R1", int'(fast_o), 1, "fast in reset");
    lo_div_sel = 2'b01;
    rst_n = 1'b1;
    exp_q.push_back(0);
    exp_fast = 1'b1;
    note_inputs();
    req = "R1"; run(2, 0, 0, 0, 0, 2'b01);
    req = "R2"; run(30, 0, 0, 0, 0, 2'b01);   // ratio 2
    run(40, 0, 0, 0, 0, 2'b10);               // ratio 4
    run(40, 0, 0, 0, 0, 2'b11);               // code 11 -> ratio 4
    req = "R9"; run(20, 0, 0, 0, 0, 2'b00);   // reduced ratio 1 keeps fast high
    req = "R3"; run(24, 5, 3, 0, 0, 2'b10);   // level above threshold
    run(24, 3, 3, 0, 0, 2'b10);               // equal: no wake
    req = "R4"; run(24, 0, 0, 0, 0, 2'b10);   // level zero never wakes
    req = "R5"; run(24, 0, 7, 1, 0, 2'b10);   // busy gated off
    run(24, 0, 7, 1, 1, 2'b10);               // busy gated on
    req = "R6"; run(24, 0, 7, 0, 1, 2'b01);   // falls back to reduced rate
    req = "R7";
    run(9, 0, 0, 0, 0, 2'b10);
    for (int k = 0; k < 8; k++) begin
      cyc(6, 1, 0, 0, 2'b10);                 // one-cycle wake pulse
      run(11, 0, 0, 0, 0, 2'b10);
    end
    for (int k = 0; k < 2000; k++) begin
      lvl = $urandom_range(0, 7); thr = $urandom_range(0, 7);
      b = 1'($urandom_range(0, 1)); e = 1'($urandom_range(0, 1));
      s = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) begin lvl = 0; b = 0; end
      run($urandom_range(1, 6), lvl, thr, b, e, s);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule